// File: doc/BRIEF.md
# Single-Phase Bus Master Sequencer

This block is the initiator side of a 32-bit multiplexed address/data parallel bus. It watches the head of a request queue. When the queue holds an entry, it asks the central arbiter for the bus. Once granted, it runs one address phase and then exactly one data phase. It then reports the outcome back through a response queue.

Three outcomes are handled:
- **Normal completion.** The transfer finishes and, for a read, returns the data.
- **Retry.** The target asks to be retried. The request stays at the queue head and the sequencer re-arbitrates for it at once.
- **Target abort.** The target refuses the request. The request is dropped and an error is returned.

Whatever the outcome, the sequencer passes through a recovery cycle before it looks at the queue's empty flag again. This gives the queue time to retire the entry it just popped.

The block also does three conversions:
- It turns the 2-bit request command into a 4-bit bus command.
- It turns active-high byte enables into the active-low byte-enable lanes.
- It generates even parity over the driven lanes, one clock late.

Top module: `pci_master_seq`

## Requirements
- R1: While reset is held, REQ, FRAME and IRDY are high, the AD drive enable is low, the C/BE lanes are 4'b1111, PAR is 0, and neither pop nor push is pulsed.
- R2: With the queue empty the block never requests the bus, and a grant that arrives while idle starts nothing. One cycle after the queue becomes non-empty in idle, REQ goes low.
- R3: REQ stays low until GNT is sampled low. The next cycle is the address phase: FRAME is low, AD carries the request address with the drive enable high, and C/BE carries 4'b0111 for command 2'b10 (write) or 4'b0110 for any other command (read).
- R4: In the data phase FRAME is high, IRDY is low and C/BE carries the inverted byte enables. For a write, AD carries the write data with the drive enable high. For a read, the drive enable is low. FRAME and IRDY are never low together.
- R5: A data phase that samples TRDY low completes normally. Both kinds pulse pop for one cycle. A write pushes nothing. A read pushes AD-in with the error flag at 0, in the same cycle as the pop.
- R6: STOP low, DEVSEL low and TRDY high in the data phase is a retry. There is no pop and no push, and REQ is low again in the very next cycle for the same request.
- R7: STOP low, DEVSEL high and TRDY high in the data phase is a target abort. It pops the request and pushes a response with the error flag at 1 and data 0, in the same cycle.
- R8: After a completed transfer the bus is not requested again too soon, even when the queue is already non-empty. The first cycle with REQ low comes 2 cycles after the pop cycle for a write or an abort, and 3 cycles after it for a successful read.
- R9: PAR in each cycle equals the XOR of all AD-out and C/BE-out lanes of the previous cycle.
- R10: While TRDY and STOP are both high in the data phase, IRDY stays low and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_empty_i | input | 1 | Request queue empty |
| rq_addr_i | input | 32 | Head request address |
| rq_cmd_i | input | 2 | Head request command (2'b10 write, else read) |
| rq_be_i | input | 4 | Head request byte enables, active high |
| rq_wdata_i | input | 32 | Head request write data |
| rq_pop_o | output | 1 | Retire head request |
| rs_push_o | output | 1 | Push a response |
| rs_data_o | output | 32 | Response read data |
| rs_err_o | output | 1 | Response error flag |
| bus_req_n_o | output | 1 | Bus request to arbiter, active low |
| bus_gnt_n_i | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | Cycle frame, active low |
| irdy_n_o | output | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop, active low |
| devsel_n_i | input | 1 | Device select, active low |
| ad_o | output | 32 | Address/data out |
| ad_oe_o | output | 1 | AD drive enable |
| ad_i | input | 32 | Address/data in |
| cbe_n_o | output | 4 | Command/byte-enable lanes, active low |
| par_o | output | 1 | Even parity of previous cycle's AD and C/BE |

## Verification
Transactions are driven with four target behaviours: immediate completion, added target wait states, retry followed by success, and target abort. Each behaviour is tried for both reads and writes, which separates the push-with-data path, the push-with-error path, the silent-pop path and the re-arbitration path. Grant delays and wait-state counts are varied, which shows that REQ and IRDY are held rather than pulsed. Back-to-back requests measure the recovery gap. Read-back patterns such as 32'hDEADBEEF and alternating-bit addresses expose lane and parity mistakes.

// File: rtl/pci_seq_pkg.sv
package pci_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RDONE,
    ST_RECOV
  } seq_state_t;

  localparam logic [1:0] REQ_CMD_WRITE = 2'b10;
  localparam logic [3:0] BUS_MEM_RD    = 4'b0110;
  localparam logic [3:0] BUS_MEM_WR    = 4'b0111;

  function automatic logic cmd_is_write(input logic [1:0] cmd);
    return cmd == REQ_CMD_WRITE;
  endfunction

  function automatic logic [3:0] cmd_to_bus(input logic [1:0] cmd);
    return cmd_is_write(cmd) ? BUS_MEM_WR : BUS_MEM_RD;
  endfunction

endpackage

// File: rtl/pci_seq_ctrl.sv
module pci_seq_ctrl
  import pci_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty_i,
  input  logic              q_is_write_i,
  input  logic              gnt_n_i,
  input  logic              trdy_n_i,
  input  logic              stop_n_i,
  input  logic              devsel_n_i,
  input  logic [DATA_W-1:0] ad_i,
  output seq_state_t        state_o,
  output logic              req_n_o,
  output logic              frame_n_o,
  output logic              irdy_n_o,
  output logic              pop_o,
  output logic              push_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);

  seq_state_t st_q, st_d;
  logic in_data, done_ok, retry, abort;
  logic pop_d, push_d, err_d;
  logic pop_q, push_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  assign in_data = (st_q == ST_WDATA) || (st_q == ST_RDATA);
  assign done_ok = !trdy_n_i;
  assign retry   = trdy_n_i && !stop_n_i && !devsel_n_i;
  assign abort   = trdy_n_i && !stop_n_i && devsel_n_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RESET: st_d = ST_IDLE;
      ST_IDLE:  if (!q_empty_i) st_d = ST_ARB;
      ST_ARB:   if (!gnt_n_i) st_d = ST_ADDR;
      ST_ADDR:  st_d = q_is_write_i ? ST_WDATA : ST_RDATA;
      ST_WDATA: begin
        if (retry)                 st_d = ST_ARB;
        else if (done_ok || abort) st_d = ST_RECOV;
      end
      ST_RDATA: begin
        if (retry)        st_d = ST_ARB;
        else if (done_ok) st_d = ST_RDONE;
        else if (abort)   st_d = ST_RECOV;
      end
      ST_RDONE: st_d = ST_RECOV;
      ST_RECOV: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pop_d  = in_data && (done_ok || abort);
    push_d = in_data && (abort || (st_q == ST_RDATA && done_ok));
    err_d  = in_data && abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RESET;
      pop_q  <= 1'b0;
      push_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pop_q  <= pop_d;
      push_q <= push_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (push_d) begin
      rdata_q <= abort ? '0 : ad_i;
    end
  end

  assign state_o   = st_q;
  assign req_n_o   = (st_q != ST_ARB);
  assign frame_n_o = (st_q != ST_ADDR);
  assign irdy_n_o  = !in_data;
  assign pop_o     = pop_q;
  assign push_o    = push_q;
  assign err_o     = err_q;
  assign rdata_o   = rdata_q;

  // R3: request held until grant sampled
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n_o && gnt_n_i) |=> !req_n_o);

  // R4: address and data phase never overlap
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!frame_n_o && !irdy_n_o));

  // R5: every push retires the head entry in the same cycle
  a_r5_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> pop_o);

  // R6: retry re-arbitrates without touching the queues
  a_r6_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && trdy_n_i && !stop_n_i && !devsel_n_i) |=> (!req_n_o && !pop_o && !push_o));

  // R7: abort returns an error response
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && trdy_n_i && !stop_n_i && devsel_n_i) |=> (pop_o && push_o && err_o));

  // R8: no arbitration during or right after the retire cycle
  a_r8_recov_now: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> req_n_o);
  a_r8_recov_next: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> req_n_o);

  // R10: initiator stays ready through target wait states
  a_r10_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_o && trdy_n_i && stop_n_i) |=> (!irdy_n_o && !pop_o));

endmodule

// File: rtl/pci_seq_drive.sv
module pci_seq_drive
  import pci_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  seq_state_t        state_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [1:0]        cmd_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [BE_W-1:0]   cbe_n_o
);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    cbe_n_o = '1;
    case (state_i)
      ST_ADDR: begin
        ad_o    = addr_i;
        ad_oe_o = 1'b1;
        cbe_n_o = cmd_to_bus(cmd_i);
      end
      ST_WDATA: begin
        ad_o    = wdata_i;
        ad_oe_o = 1'b1;
        cbe_n_o = ~be_i;
      end
      ST_RDATA: begin
        cbe_n_o = ~be_i;
      end
      default: begin
        ad_o    = '0;
        ad_oe_o = 1'b0;
        cbe_n_o = '1;
      end
    endcase
  end

endmodule

// File: rtl/pci_seq_parity.sv
module pci_seq_parity #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_n_i,
  output logic              par_o
);

  logic par_q, par_en;

  assign par_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
    end else if (par_en) begin
      par_q <= ^{ad_i, cbe_n_i};
    end
  end

  assign par_o = par_q;

  // R9: parity trails the lanes it covers by one clock
  a_r9_parity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_o == ^$past({ad_i, cbe_n_i})));

endmodule

// File: rtl/pci_master_seq.sv
module pci_master_seq
  import pci_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_empty_i,
  input  logic [DATA_W-1:0] rq_addr_i,
  input  logic [1:0]        rq_cmd_i,
  input  logic [BE_W-1:0]   rq_be_i,
  input  logic [DATA_W-1:0] rq_wdata_i,
  output logic              rq_pop_o,
  output logic              rs_push_o,
  output logic [DATA_W-1:0] rs_data_o,
  output logic              rs_err_o,
  output logic              bus_req_n_o,
  input  logic              bus_gnt_n_i,
  output logic              frame_n_o,
  output logic              irdy_n_o,
  input  logic              trdy_n_i,
  input  logic              stop_n_i,
  input  logic              devsel_n_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [BE_W-1:0]   cbe_n_o,
  output logic              par_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  seq_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pci_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .q_empty_i    (rq_empty_i),
    .q_is_write_i (cmd_is_write(rq_cmd_i)),
    .gnt_n_i      (bus_gnt_n_i),
    .trdy_n_i     (trdy_n_i),
    .stop_n_i     (stop_n_i),
    .devsel_n_i   (devsel_n_i),
    .ad_i         (ad_i),
    .state_o      (state),
    .req_n_o      (bus_req_n_o),
    .frame_n_o    (frame_n_o),
    .irdy_n_o     (irdy_n_o),
    .pop_o        (rq_pop_o),
    .push_o       (rs_push_o),
    .err_o        (rs_err_o),
    .rdata_o      (rs_data_o)
  );

  pci_seq_drive #(.DATA_W(DATA_W), .BE_W(BE_W)) u_drive (
    .state_i (state),
    .addr_i  (rq_addr_i),
    .cmd_i   (rq_cmd_i),
    .be_i    (rq_be_i),
    .wdata_i (rq_wdata_i),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .cbe_n_o (cbe_n_o)
  );

  pci_seq_parity #(.DATA_W(DATA_W), .BE_W(BE_W)) u_par (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ad_i    (ad_o),
    .cbe_n_i (cbe_n_o),
    .par_o   (par_o)
  );

endmodule

// File: tb/pci_master_seq_test.sv
module pci_master_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_empty_i = 1'b1;
  logic [31:0] rq_addr_i = '0;
  logic [1:0]  rq_cmd_i = '0;
  logic [3:0]  rq_be_i = '0;
  logic [31:0] rq_wdata_i = '0;
  logic        bus_gnt_n_i = 1'b1;
  logic        trdy_n_i = 1'b1;
  logic        stop_n_i = 1'b1;
  logic        devsel_n_i = 1'b1;
  logic [31:0] ad_i = '0;
  logic        rq_pop_o, rs_push_o, rs_err_o, bus_req_n_o, frame_n_o, irdy_n_o, ad_oe_o, par_o;
  logic [31:0] rs_data_o, ad_o;
  logic [3:0]  cbe_n_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  pci_master_seq uut (.*);

  // addr, cmd, be, wdata, kind(0 ok,1 retry,2 abort), rdata, delay
  localparam logic [107:0] VEC [6] = '{
    {32'h0000_1000, 2'b10, 4'hF, 32'hA5A5_1234, 2'd0, 32'h0000_0000, 4'd0},
    {32'h0000_2004, 2'b01, 4'h3, 32'h0000_0000, 2'd0, 32'hDEAD_BEEF, 4'd2},
    {32'h0000_300C, 2'b10, 4'h1, 32'h0000_0001, 2'd1, 32'h0000_0000, 4'd1},
    {32'hF000_0000, 2'b01, 4'hF, 32'h0000_0000, 2'd2, 32'h1111_1111, 4'd0},
    {32'h8000_0010, 2'b10, 4'hC, 32'hFFFF_0000, 2'd2, 32'h0000_0000, 4'd3},
    {32'h5555_AAA8, 2'b00, 4'h8, 32'h0000_0000, 2'd1, 32'h1357_9BDF, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [107:0] v, input bit keep);
    logic [31:0] addr, wd, rd;
    logic [1:0] cmd, kind;
    logic [3:0] be, cmdc, dly;
    bit wr, done;
    {addr, cmd, be, wd, kind, rd, dly} = v;
    wr   = (cmd == 2'b10);
    cmdc = wr ? 4'b0111 : 4'b0110;
    @(negedge clk);
    rq_addr_i = addr; rq_cmd_i = cmd; rq_be_i = be; rq_wdata_i = wd; rq_empty_i = 1'b0;
    done = 0;
    while (!done) begin
      for (int i = 0; i < 20; i++) begin
        if (!bus_req_n_o) break;
        @(negedge clk);
      end
      chk(!bus_req_n_o, "R2 req on non-empty", {31'd0, bus_req_n_o}, 32'd0);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(!bus_req_n_o && frame_n_o, "R3 req held w/o grant", {30'd0, bus_req_n_o, frame_n_o}, 32'd1);
      end
      bus_gnt_n_i = 1'b0;
      @(negedge clk);
      bus_gnt_n_i = 1'b1;
      chk(!frame_n_o && ad_oe_o && ad_o == addr, "R3 address phase", ad_o, addr);
      chk(cbe_n_o == cmdc, "R3 command code", {28'd0, cbe_n_o}, {28'd0, cmdc});
      @(negedge clk);
      chk(par_o == ^{addr, cmdc}, "R9 address parity", {31'd0, par_o}, {31'd0, ^{addr, cmdc}});
      chk(frame_n_o && !irdy_n_o && cbe_n_o == ~be, "R4 data phase lanes", {28'd0, cbe_n_o}, {28'd0, ~be});
      chk(ad_oe_o == wr && (!wr || ad_o == wd), "R4 data drive", ad_o, wr ? wd : 32'd0);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(!irdy_n_o && !rq_pop_o, "R10 wait state hold", {30'd0, irdy_n_o, rq_pop_o}, 32'd0);
      end
      if (kind == 2'd0) begin trdy_n_i = 1'b0; devsel_n_i = 1'b0; ad_i = rd; end
      else if (kind == 2'd1) begin stop_n_i = 1'b0; devsel_n_i = 1'b0; end
      else begin stop_n_i = 1'b0; devsel_n_i = 1'b1; end
      @(negedge clk);
      trdy_n_i = 1'b1; stop_n_i = 1'b1; devsel_n_i = 1'b1; ad_i = '0;
      if (kind == 2'd1) begin
        chk(!bus_req_n_o && !rq_pop_o && !rs_push_o && irdy_n_o, "R6 retry re-arbitrates",
            {29'd0, bus_req_n_o, rq_pop_o, rs_push_o}, 32'd0);
        kind = 2'd0;
        dly  = 4'd0;
      end else begin
        done = 1;
        chk(rq_pop_o, "R5 pop on finish", {31'd0, rq_pop_o}, 32'd1);
        if (kind == 2'd2)
          chk(rs_push_o && rs_err_o && rs_data_o == 32'd0, "R7 abort error response", rs_data_o, 32'd0);
        else if (wr)
          chk(!rs_push_o, "R5 write pushes nothing", {31'd0, rs_push_o}, 32'd0);
        else
          chk(rs_push_o && !rs_err_o && rs_data_o == rd, "R5 read data response", rs_data_o, rd);
        chk(par_o == ^{(wr ? wd : 32'd0), ~be}, "R9 data parity", {31'd0, par_o},
            {31'd0, ^{(wr ? wd : 32'd0), ~be}});
        if (!keep) rq_empty_i = 1'b1;
      end
    end
  endtask

  task automatic recov_gap(input int exp);
    int n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
      if (!bus_req_n_o) break;
    end
    chk(n == exp, "R8 recovery gap", n, exp);
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req_n_o && frame_n_o && irdy_n_o && !ad_oe_o && cbe_n_o == 4'hF && !par_o
        && !rq_pop_o && !rs_push_o, "R1 reset outputs", {28'd0, cbe_n_o}, 32'hF);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(bus_req_n_o, "R2 no request when empty", {31'd0, bus_req_n_o}, 32'd1);
    bus_gnt_n_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(frame_n_o && irdy_n_o, "R2 idle grant ignored", {30'd0, frame_n_o, irdy_n_o}, 32'd3);
    end
    bus_gnt_n_i = 1'b1;

    for (int k = 0; k < 6; k++) begin
      run_txn(VEC[k], 1'b0);
      repeat (4) @(negedge clk);
    end

    run_txn(VEC[0], 1'b1);
    recov_gap(2);
    run_txn(VEC[1], 1'b1);
    recov_gap(3);
    run_txn(VEC[3], 1'b1);
    recov_gap(2);
    run_txn(VEC[3], 1'b0);
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule